// File: doc/BRIEF.md
# Atomic read-modify-write memory unit

This block sits between one requester and a single-ported synchronous memory of 64-bit words. It performs indivisible read-modify-write operations. A request gives an operation code, a byte address, a size code, up to three 64-bit operands, a byte-order flag and an ordering tag. The block reads the addressed word and works out the old value in numeric (register) order. It then writes the updated bytes back to memory. It holds a lock output high from the read until the last write, so that an external arbiter can keep every other master away from the memory.

Three operations are supported:
- Fetch-and-add over 1, 2, 4 or 8 bytes.
- Compare-and-exchange over 1, 2, 4 or 8 bytes.
- A paired 16-byte compare-and-exchange. It compares 8 bytes and, on a match, stores two 8-byte operands into an aligned 16-byte pair.

Each request ends in a one-cycle response. The response carries the old value, a flag saying whether memory was written, an error flag and the ordering tag. Only one operation is in flight at a time.

Top module: `atomic_rmw_unit`

## Requirements
- R1: Fetch-and-add (op code 0) returns the old size-byte value. It writes back the low size bytes of old plus `req_opa`, wrapping modulo 2^(8·size). Every other byte of the memory word is left unchanged, and `rsp_wrote` is 1.
- R2: Compare-and-exchange (op code 1) returns the old size-byte value. It writes the low size bytes of `req_opa` only when the old value equals the low size bytes of `req_cmp`. Otherwise memory is left unchanged. `rsp_wrote` reports whether the write happened.
- R3: The paired exchange (op code 2) reads 8 bytes at the address and compares them with `req_cmp`. On a match it writes `req_opa` at the address with bit 3 cleared, and `req_opb` at that address plus 8, using two consecutive write cycles.
- R4: With `req_big`=1, the byte at the lowest address is the most significant byte of the value, for both the read and the write. With `req_big`=0, the byte at the lowest address is the least significant byte. For the paired exchange, the reordering applies within each 8-byte half only.
- R5: A request is refused when the op code is 3, when a single-value operation is not aligned to its size, or when a paired exchange is not 8-byte aligned. A refused request returns `rsp_err`=1, `rsp_wrote`=0 and `rsp_old`=0, and causes no memory access.
- R6: `rsp_rel` echoes the request's `req_rel` tag (0 acquire, 1 release) for every request, including refused ones.
- R7: `req_ready` is high only when the block is idle, and `rsp_valid` is a one-cycle pulse. Counting from the accepting edge, the response comes 1 cycle later for a refused request, 4 cycles later for a paired exchange that writes, and 3 cycles later for all other requests.
- R8: `mem_lock` is high, without a gap, from the read cycle through the last write cycle of an operation. The block never drives `mem_en` while `mem_lock` is low.
- R9: The size code is log2 of the byte count (0 to 3). Memory byte lane k of word w holds byte address 8·w+k. The paired exchange ignores the size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_op | input | 2 | 0 fetch-add, 1 compare-exchange, 2 paired exchange, 3 reserved |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | log2 of byte count |
| req_opa | input | 64 | Add operand, or store data (first half for the paired exchange) |
| req_opb | input | 64 | Second-half store data for the paired exchange |
| req_cmp | input | 64 | Compare value |
| req_big | input | 1 | 1 selects big-endian byte order |
| req_rel | input | 1 | Ordering tag: 0 acquire, 1 release |
| rsp_valid | output | 1 | Response pulse |
| rsp_old | output | 64 | Old value in register order, zero-extended |
| rsp_wrote | output | 1 | Memory was written |
| rsp_err | output | 1 | Request refused |
| rsp_rel | output | 1 | Echoed ordering tag |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-3 | Memory word address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid one cycle after a read |
| mem_lock | output | 1 | Memory reserved for this block |

## Verification
The bench builds the block with the default AW=12, which gives a 512-word memory mirrored by a byte-wise reference model. Random requests are confined to the lowest 64 bytes, so operations overlap heavily. Half of the compare values are taken from the model's current contents, which makes matches and misses about equally likely. Misaligned addresses and the reserved op code arise from the same random draw. Directed cases add a 1-byte add that wraps inside an all-ones word, and a big-endian paired exchange issued with address bit 3 set.

// File: rtl/atomic_pkg.sv
package atomic_pkg;

  typedef enum logic [1:0] {
    OP_FADD  = 2'd0,
    OP_CAS   = 2'd1,
    OP_CAS16 = 2'd2,
    OP_RSVD  = 2'd3
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MOD,
    ST_WR1,
    ST_RSP
  } amo_st_e;

  // reverse the eight bytes of a 64-bit value
  function automatic logic [63:0] swap_bytes64(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      r[8*i +: 8] = v[8*(7-i) +: 8];
    end
    return r;
  endfunction

  // all-ones mask covering 2^lg bytes
  function automatic logic [63:0] lane_mask(input logic [1:0] lg);
    logic [63:0] m;
    case (lg)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/amo_datapath.sv
module amo_datapath
  import atomic_pkg::*;
(
  input  logic [63:0] rdata,
  input  amo_op_e     op,
  input  logic [2:0]  off,
  input  logic [1:0]  lg,
  input  logic        big,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic [63:0] cmp,
  output logic [63:0] old_val,
  output logic        do_write,
  output logic [63:0] word_a,
  output logic [63:0] word_b
);

  logic [63:0] mask, raw, nv, mform, merged;
  logic [5:0]  sh;
  logic [3:0]  nb;
  logic [6:0]  rs;
  logic        eq;

  always_comb begin
    mask    = lane_mask(lg);
    sh      = {off, 3'b000};
    nb      = 4'd1 << lg;
    rs      = 7'd64 - {nb, 3'b000};
    // memory-order field, then register order
    raw     = (rdata >> sh) & mask;
    old_val = big ? (swap_bytes64(raw) >> rs) : raw;
    eq      = (old_val == (cmp & mask));
    nv      = '0;
    do_write = 1'b0;
    case (op)
      OP_FADD:  begin nv = (old_val + opa) & mask; do_write = 1'b1; end
      OP_CAS:   begin nv = opa & mask;             do_write = eq;   end
      OP_CAS16: begin nv = '0;                     do_write = eq;   end
      default:  begin nv = '0;                     do_write = 1'b0; end
    endcase
    mform  = big ? (swap_bytes64(nv) >> rs) : nv;
    merged = (rdata & ~(mask << sh)) | (mform << sh);
    word_a = (op == OP_CAS16) ? (big ? swap_bytes64(opa) : opa) : merged;
    word_b = big ? swap_bytes64(opb) : opb;
  end

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import atomic_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [63:0]   req_opa,
  input  logic [63:0]   req_opb,
  input  logic [63:0]   req_cmp,
  input  logic          req_big,
  input  logic          req_rel,
  // datapath side
  output amo_op_e       q_op,
  output logic [2:0]    q_off,
  output logic [1:0]    q_lg,
  output logic          q_big,
  output logic [63:0]   q_opa,
  output logic [63:0]   q_opb,
  output logic [63:0]   q_cmp,
  input  logic [63:0]   dp_old,
  input  logic          dp_write,
  input  logic [63:0]   dp_word_a,
  input  logic [63:0]   dp_word_b,
  // response
  output logic          rsp_valid,
  output logic [63:0]   rsp_old,
  output logic          rsp_wrote,
  output logic          rsp_err,
  output logic          rsp_rel,
  // memory
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-4:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic          mem_lock
);

  localparam int WAW = AW - 3;

  amo_st_e        st_q, st_d;
  logic [AW-1:0]  addr_q;
  logic           err_q, rel_q, wrote_q;
  logic [63:0]    old_q;
  logic           load_en, cap_en, err_in;
  logic [3:0]     amask;
  logic [WAW-1:0] wa_rd, wa_lo, wa_hi;

  // request check
  always_comb begin
    amask = (4'd1 << req_size) - 4'd1;
    if (req_op == OP_RSVD)        err_in = 1'b1;
    else if (req_op == OP_CAS16)  err_in = (req_addr[2:0] != 3'd0);
    else                          err_in = ((req_addr[2:0] & amask[2:0]) != 3'd0);
  end

  // next state
  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        load_en = 1'b1;
        st_d    = err_in ? ST_RSP : ST_RD;
      end
      ST_RD:   st_d = ST_MOD;
      ST_MOD: begin
        cap_en = 1'b1;
        st_d   = (q_op == OP_CAS16 && dp_write) ? ST_WR1 : ST_RSP;
      end
      ST_WR1:  st_d = ST_RSP;
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      q_op <= OP_FADD; addr_q <= '0; q_lg <= '0; q_big <= 1'b0;
      rel_q <= 1'b0; err_q <= 1'b0; q_opa <= '0; q_opb <= '0; q_cmp <= '0;
    end else if (load_en) begin
      q_op   <= amo_op_e'(req_op);
      addr_q <= req_addr;
      q_lg   <= (req_op == OP_CAS16) ? 2'd3 : req_size;
      q_big  <= req_big;
      rel_q  <= req_rel;
      err_q  <= err_in;
      q_opa  <= req_opa;
      q_opb  <= req_opb;
      q_cmp  <= req_cmp;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0; wrote_q <= 1'b0;
    end else if (load_en) begin
      old_q <= '0; wrote_q <= 1'b0;
    end else if (cap_en) begin
      old_q <= dp_old; wrote_q <= dp_write;
    end
  end

  assign q_off = addr_q[2:0];
  assign wa_rd = addr_q[AW-1:3];
  assign wa_lo = {addr_q[AW-1:4], 1'b0};
  assign wa_hi = {addr_q[AW-1:4], 1'b1};

  always_comb begin
    mem_en    = (st_q == ST_RD) || (st_q == ST_MOD && dp_write) || (st_q == ST_WR1);
    mem_we    = (st_q == ST_MOD && dp_write) || (st_q == ST_WR1);
    mem_lock  = (st_q == ST_RD) || (st_q == ST_MOD) || (st_q == ST_WR1);
    mem_wdata = (st_q == ST_WR1) ? dp_word_b : dp_word_a;
    case (st_q)
      ST_MOD:  mem_addr = (q_op == OP_CAS16) ? wa_lo : wa_rd;
      ST_WR1:  mem_addr = wa_hi;
      default: mem_addr = wa_rd;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RSP);
  assign rsp_old   = old_q;
  assign rsp_wrote = wrote_q;
  assign rsp_err   = err_q;
  assign rsp_rel   = rel_q;

  assert_refused_no_access_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_ready && req_valid && err_in) |=> (!mem_en && rsp_valid && rsp_err));
  assert_refused_no_write_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_err) |-> !rsp_wrote);
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> (!rsp_valid && req_ready));
  assert_second_write_follows_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_WR1) |-> ($past(mem_we) && mem_lock));
  assert_read_precedes_modify_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_MOD) |-> ($past(mem_en) && !$past(mem_we) && $past(mem_lock)));
  assert_tag_held_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!req_ready && !rsp_valid) |=> $stable(rsp_rel));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [63:0]   req_opa,
  input  logic [63:0]   req_opb,
  input  logic [63:0]   req_cmp,
  input  logic          req_big,
  input  logic          req_rel,
  output logic          rsp_valid,
  output logic [63:0]   rsp_old,
  output logic          rsp_wrote,
  output logic          rsp_err,
  output logic          rsp_rel,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-4:0] mem_addr,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata,
  output logic          mem_lock
);

  logic [1:0]  rst_sync;
  logic        rst_ni;
  amo_op_e     q_op;
  logic [2:0]  q_off;
  logic [1:0]  q_lg;
  logic        q_big;
  logic [63:0] q_opa, q_opb, q_cmp, dp_old, dp_word_a, dp_word_b;
  logic        dp_write;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  amo_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_ni(rst_ni),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_size(req_size), .req_opa(req_opa),
    .req_opb(req_opb), .req_cmp(req_cmp), .req_big(req_big), .req_rel(req_rel),
    .q_op(q_op), .q_off(q_off), .q_lg(q_lg), .q_big(q_big),
    .q_opa(q_opa), .q_opb(q_opb), .q_cmp(q_cmp),
    .dp_old(dp_old), .dp_write(dp_write), .dp_word_a(dp_word_a), .dp_word_b(dp_word_b),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_wrote(rsp_wrote),
    .rsp_err(rsp_err), .rsp_rel(rsp_rel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_lock(mem_lock)
  );

  amo_datapath u_dp (
    .rdata(mem_rdata), .op(q_op), .off(q_off), .lg(q_lg), .big(q_big),
    .opa(q_opa), .opb(q_opb), .cmp(q_cmp),
    .old_val(dp_old), .do_write(dp_write), .word_a(dp_word_a), .word_b(dp_word_b)
  );

endmodule

// File: tb/atomic_rmw_unit_tb.sv
module atomic_rmw_unit_tb;

  localparam int AW = 12;
  localparam int NW = 1 << (AW - 3);
  localparam int NB = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_big, req_rel;
  logic [1:0]    req_op, req_size;
  logic [AW-1:0] req_addr;
  logic [63:0]   req_opa, req_opb, req_cmp;
  logic          rsp_valid, rsp_wrote, rsp_err, rsp_rel;
  logic [63:0]   rsp_old;
  logic          mem_en, mem_we, mem_lock;
  logic [AW-4:0] mem_addr;
  logic [63:0]   mem_wdata, mem_rdata;

  logic [63:0]   mem [NW];
  logic [7:0]    refb [NB];
  int            n_chk = 0, n_fail = 0, n_acc = 0, n_unlocked = 0;

  always #5 clk = ~clk;

  atomic_rmw_unit #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_opa(req_opa), .req_opb(req_opb), .req_cmp(req_cmp),
    .req_big(req_big), .req_rel(req_rel),
    .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_wrote(rsp_wrote),
    .rsp_err(rsp_err), .rsp_rel(rsp_rel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_lock(mem_lock)
  );

  // memory model, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      n_acc++;
      if (!mem_lock) n_unlocked++;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_rd(input int a, input int nb, input logic big);
    logic [63:0] v = '0;
    for (int i = 0; i < nb; i++) begin
      if (big) v = (v << 8) | 64'(refb[a+i]);
      else     v = v | (64'(refb[a+i]) << (8*i));
    end
    return v;
  endfunction

  task automatic ref_wr(input int a, input int nb, input logic big, input logic [63:0] v);
    for (int i = 0; i < nb; i++) begin
      refb[a+i] = big ? 8'(v >> (8*(nb-1-i))) : 8'(v >> (8*i));
    end
  endtask

  function automatic logic [63:0] ref_word(input int w);
    logic [63:0] v = '0;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = refb[8*w+k];
    return v;
  endfunction

  task automatic do_op(input logic [1:0] op, input int a, input logic [1:0] lg,
                       input logic [63:0] opa, input logic [63:0] opb,
                       input logic [63:0] cmp, input logic big, input logic rel);
    int nb, n, acc0, lat, base;
    logic err, wr;
    logic [63:0] old, mk;
    string tg;
    nb   = (op == 2'd2) ? 8 : (1 << lg);
    mk   = (nb == 8) ? '1 : ((64'd1 << (8*nb)) - 64'd1);
    err  = (op == 2'd3) || ((a % nb) != 0);
    old  = '0;
    wr   = 1'b0;
    tg   = err ? "R5" : (big ? "R4" : (op == 2'd0 ? "R1" : (op == 2'd1 ? "R2" : "R3")));
    base = (a / 16) * 16;
    if (!err) begin
      old = ref_rd(a, nb, big);
      case (op)
        2'd0: begin wr = 1'b1; ref_wr(a, nb, big, (old + opa) & mk); end
        2'd1: begin wr = (old == (cmp & mk)); if (wr) ref_wr(a, nb, big, opa & mk); end
        default: begin
          wr = (old == cmp);
          if (wr) begin ref_wr(base, 8, big, opa); ref_wr(base + 8, 8, big, opb); end
        end
      endcase
    end
    lat = err ? 1 : ((op == 2'd2 && wr) ? 4 : 3);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_size = lg;
    req_opa = opa; req_opb = opb; req_cmp = cmp; req_big = big; req_rel = rel;
    acc0 = n_acc;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = 1'b0;
        chk("R7 ready low after accept", 64'(req_ready), 64'd0);
      end
    end while (!rsp_valid && n < 20);
    chk("R7 latency", 64'(n), 64'(lat));
    chk({tg, " old"},   rsp_old,          old);
    chk({tg, " wrote"}, 64'(rsp_wrote),   64'(wr));
    chk("R5 err",       64'(rsp_err),     64'(err));
    chk("R6 tag",       64'(rsp_rel),     64'(rel));
    if (err) chk("R5 no access", 64'(n_acc - acc0), 64'd0);
    chk({tg, " R9 word0"}, mem[base/8],   ref_word(base/8));
    chk({tg, " R9 word1"}, mem[base/8+1], ref_word(base/8+1));
    @(negedge clk);
    chk("R7 pulse", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R7 actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin
      w = {$urandom, $urandom};
      mem[i] = w;
      for (int k = 0; k < 8; k++) refb[8*i+k] = w[8*k +: 8];
    end
    req_valid = 1'b0; req_op = '0; req_addr = '0; req_size = '0;
    req_opa = '0; req_opb = '0; req_cmp = '0; req_big = 1'b0; req_rel = 1'b0;
    mem_rdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset ready", 64'(req_ready), 64'd1);
    chk("R7 reset rsp",   64'(rsp_valid), 64'd0);
    chk("R8 reset lock",  64'(mem_lock),  64'd0);

    // directed: wrap of a single byte inside an all-ones word (R1)
    do_op(2'd1, 8, 2'd3, '1, '0, ref_rd(8, 8, 1'b0), 1'b0, 1'b0);
    do_op(2'd0, 11, 2'd0, 64'd1, '0, '0, 1'b0, 1'b1);
    do_op(2'd0, 8, 2'd3, 64'd1, '0, '0, 1'b0, 1'b0);
    // big-endian paired exchange with bit 3 set (R3, R4)
    do_op(2'd2, 24, 2'd0, 64'h0102030405060708, 64'h1112131415161718,
          ref_rd(24, 8, 1'b1), 1'b1, 1'b1);
    do_op(2'd2, 40, 2'd0, 64'h5, 64'h6, ~ref_rd(40, 8, 1'b0), 1'b0, 1'b0);
    // big-endian 2-byte compare-exchange hit (R4)
    do_op(2'd1, 50, 2'd1, 64'hABCD, '0, ref_rd(50, 2, 1'b1), 1'b1, 1'b0);
    // refusals (R5)
    do_op(2'd0, 1, 2'd1, 64'd1, '0, '0, 1'b0, 1'b1);
    do_op(2'd3, 0, 2'd0, 64'd1, '0, '0, 1'b0, 1'b0);
    do_op(2'd2, 4, 2'd0, 64'd1, '0, '0, 1'b0, 1'b1);

    for (int t = 0; t < 400; t++) begin
      logic [1:0] op, lg;
      logic big;
      int a, nb;
      logic [63:0] cmp;
      op  = ($urandom % 10 == 0) ? 2'd3 : 2'($urandom % 3);
      lg  = 2'($urandom % 4);
      a   = int'($urandom % 64);
      big = 1'($urandom);
      nb  = (op == 2'd2) ? 8 : (1 << lg);
      if ($urandom % 4 != 0) a = (a / nb) * nb;
      cmp = {$urandom, $urandom};
      if ($urandom % 2 == 0 && a + nb <= NB) cmp = ref_rd(a, nb, big);
      do_op(op, a, lg, {$urandom, $urandom}, {$urandom, $urandom}, cmp, big, 1'($urandom));
    end

    chk("R8 access outside lock", 64'(n_unlocked), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule